// File: doc/BRIEF.md
# MDIO Station Management Master

This block gives a host a simple way to read and write the management registers inside an Ethernet PHY. It makes the management clock (MDC) from the system clock through a programmable divider. It also shifts serial frames out on the management data line, which the block drives through an output-enable pair so that the pad can be placed outside it. The host holds a request line high until the block returns a one-cycle start pulse for that operation, then drops the request.

A read frame returns a 16-bit value together with a one-cycle update strobe. A scan request makes the block read the addressed register over and over, with no idle time between frames, for as long as the request stays up. While scanning, the block derives a link-fail flag from each result. A qualifier flag marks the scan result as stale until the first scan frame has completed.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, mdio_oe, rd_update, both start pulses, link_fail, scan_invalid and rd_data are all zero.
- R2: The MDC period is max(div, 2) system clock cycles, so MDC is high for at least one cycle and low for at least one cycle.
- R3: A frame is shifted most significant bit first. It consists of 32 ones as a preamble (left out when no_pre is 1), then the start code 01, then the opcode (01 write, 10 read), then the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround and 16 data bits. On a write, the turnaround is driven as 10 and the data is wr_data.
- R4: A frame starts on an MDC falling edge. write_start pulses for one cycle when a write frame begins, and read_start pulses for one cycle when a read frame begins. The two never pulse together. If several requests are pending, write wins over read, and read wins over scan.
- R5: During a read, mdio_oe is low for the turnaround and data bits. The 16 bits on mdio_i are sampled at MDC rising edges. At the end of the frame, rd_data takes the value and rd_update is high for exactly one cycle.
- R6: While mdio_oe stays high, mdio_o changes only on the cycle in which MDC falls.
- R7: While req_scan is high, reads of the addressed register follow one another back to back, with no read_start pulse. scan_invalid rises when scanning begins and falls with the first completed scan result. After each scan result, link_fail equals the inverse of bit 2 of that result.
- R8: busy rises when a frame begins and stays high until the MDC falling edge that follows the frame's last bit. If a request is pending at that edge, the next frame begins with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div | input | 8 | MDC divide ratio |
| no_pre | input | 1 | Leave out the preamble |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for write frames |
| req_write | input | 1 | Write request, held until write_start |
| req_read | input | 1 | Read request, held until read_start |
| req_scan | input | 1 | Continuous scan request |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pad |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Last value read |
| rd_update | output | 1 | One-cycle strobe for a new rd_data |
| link_fail | output | 1 | Last scan result had bit 2 clear |
| scan_invalid | output | 1 | Scan result not yet valid |
| write_start | output | 1 | Write frame began |
| read_start | output | 1 | Read frame began |

## Verification
Several properties are checked on every cycle by the assertions. The start pulses never coincide, and each is followed by busy. Busy only rises on an MDC fall, and the driven data only changes on an MDC fall. rd_data never moves without rd_update, rd_update lasts one cycle, and scan_invalid only falls along with a result. Other behaviour can only be shown by the scenarios, using a PHY responder in the bench: the actual bit layout of each frame, the presence or absence of the preamble, and the MDC period for various divider values. The scenarios also show the priority order under simultaneous requests, that scan frames run back to back, and that link_fail follows the data returned.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div,
  input  logic              no_pre,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_write,
  input  logic              req_read,
  input  logic              req_scan,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_update,
  output logic              link_fail,
  output logic              scan_invalid,
  output logic              write_start,
  output logic              read_start
);

  localparam int FRM    = 6 + 2*ADDR_W + DATA_W;
  localparam int TOT    = PRE_LEN + FRM;
  localparam int PW     = $clog2(TOT + 1);
  localparam int TA_POS = PRE_LEN + 4 + 2*ADDR_W;
  localparam int D_POS  = TA_POS + 2;

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD, OP_SCAN} op_t;

  // clock divider
  logic [DIV_W-1:0] eff, hi_len, lo_len, cnt;
  logic tick, fall_ev, rise_ev;

  assign eff     = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign hi_len  = eff >> 1;
  assign lo_len  = eff - hi_len;
  assign tick    = (cnt <= DIV_W'(1));
  assign fall_ev = tick & mdc;
  assign rise_ev = tick & ~mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc <= 1'b0;
      cnt <= DIV_W'(1);
    end else if (tick) begin
      mdc <= ~mdc;
      cnt <= mdc ? lo_len : hi_len;
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  // frame engine
  logic             busy_q, scanning;
  op_t              op_q, pick;
  logic [PW-1:0]    pos;
  logic [FRM-1:0]   frame;
  logic [DATA_W-1:0] rx;
  logic             last, can_start, is_wr;

  assign pick = req_write ? OP_WR : req_read ? OP_RD : req_scan ? OP_SCAN : OP_NONE;
  assign is_wr = (pick == OP_WR);
  assign last = busy_q && (pos == PW'(TOT-1));
  assign can_start = fall_ev && (!busy_q || last) && (pick != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      scanning     <= 1'b0;
      op_q         <= OP_NONE;
      pos          <= '0;
      frame        <= '0;
      rx           <= '0;
      rd_data      <= '0;
      rd_update    <= 1'b0;
      link_fail    <= 1'b0;
      scan_invalid <= 1'b0;
      write_start  <= 1'b0;
      read_start   <= 1'b0;
    end else begin
      write_start <= 1'b0;
      read_start  <= 1'b0;
      rd_update   <= 1'b0;
      if (rise_ev && busy_q && op_q != OP_WR && pos >= PW'(D_POS))
        rx <= {rx[DATA_W-2:0], mdio_i};
      if (fall_ev) begin
        if (last) begin
          busy_q <= 1'b0;
          if (op_q != OP_WR) begin
            rd_data   <= rx;
            rd_update <= 1'b1;
          end
          if (op_q == OP_SCAN) begin
            link_fail    <= ~rx[2];
            scan_invalid <= 1'b0;
          end
        end else if (busy_q) begin
          pos <= pos + PW'(1);
          if (pos >= PW'(PRE_LEN)) frame <= frame << 1;
        end
        if (can_start) begin
          busy_q      <= 1'b1;
          op_q        <= pick;
          pos         <= no_pre ? PW'(PRE_LEN) : '0;
          frame       <= {2'b01, is_wr ? 2'b01 : 2'b10, phy_addr, reg_addr,
                          is_wr ? 2'b10 : 2'b11, is_wr ? wr_data : {DATA_W{1'b1}}};
          write_start <= is_wr;
          read_start  <= (pick == OP_RD);
          if (pick == OP_SCAN && !scanning) scan_invalid <= 1'b1;
          scanning    <= (pick == OP_SCAN);
        end else if (!busy_q || last) begin
          scanning <= 1'b0;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = !busy_q || pos < PW'(PRE_LEN) || frame[FRM-1];
  assign mdio_oe = busy_q && !(op_q != OP_WR && pos >= PW'(TA_POS));

  p_start_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({write_start, read_start}));
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (write_start || read_start) |=> busy);
  p_busy_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $fell(mdc));
  p_data_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> $fell(mdc));
  p_upd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rd_update |=> !rd_update);
  p_data_with_upd_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> rd_update);
  p_invalid_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_invalid) |-> rd_update);

endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic clk = 0, rst = 1;
  logic [7:0] div = 8'd4;
  logic no_pre = 0;
  logic [4:0] phy_addr = 0, reg_addr = 0;
  logic [15:0] wr_data = 0;
  logic req_write = 0, req_read = 0, req_scan = 0;
  logic mdc, mdio_o, mdio_oe, busy, rd_update, link_fail, scan_invalid, write_start, read_start;
  logic mdio_i = 1;
  logic [15:0] rd_data;

  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  mdio_master u0 (.clk(clk), .rst(rst), .div(div), .no_pre(no_pre), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .req_write(req_write), .req_read(req_read),
    .req_scan(req_scan), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .busy(busy), .rd_data(rd_data), .rd_update(rd_update), .link_fail(link_fail),
    .scan_invalid(scan_invalid), .write_start(write_start), .read_start(read_start));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // PHY responder
  logic [15:0] phy_regs [32];
  int k = -1, ones = 0, pre_seen = 0, last_pre = 0;
  int n_wr = 0, n_rd = 0, rd_oe_err = 0;
  logic [31:0] fr;
  logic [4:0] lw_phy, lw_reg;
  logic [15:0] lw_data;
  logic [1:0] lw_ta, last_op;
  logic lw_busy;

  always @(posedge mdc) begin
    if (rst) k = -1;
    else if (k < 0) begin
      if (mdio_oe && !mdio_o) begin k = 1; fr = 0; pre_seen = ones; ones = 0; end
      else if (mdio_oe) ones++;
      else ones = 0;
    end else begin
      if (mdio_oe) fr[31-k] = mdio_o;
      if (fr[29:28] == 2'b10 && k >= 14 && mdio_oe) rd_oe_err++;
      k++;
      if (k == 32) begin
        last_op = fr[29:28]; last_pre = pre_seen; lw_busy = busy;
        if (fr[29:28] == 2'b01) begin
          n_wr++; lw_phy = fr[27:23]; lw_reg = fr[22:18]; lw_ta = fr[17:16]; lw_data = fr[15:0];
        end else n_rd++;
        k = -1;
      end
    end
  end

  always @(negedge mdc) begin
    if (k >= 15 && k <= 31 && fr[29:28] == 2'b10)
      mdio_i = (k == 15) ? 1'b0 : phy_regs[fr[22:18]][31-k];
    else mdio_i = 1'b1;
  end

  // data-edge monitor (R6)
  int edge_err = 0;
  logic p_oe = 0, p_o = 1, p_mdc = 0;
  always @(negedge clk) begin
    if (!rst && mdio_oe && p_oe && mdio_o != p_o && !(p_mdc && !mdc)) edge_err++;
    p_oe = mdio_oe; p_o = mdio_o; p_mdc = mdc;
  end

  task automatic wait_pulse(input int which, output bit got);
    got = 0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (which == 0 && write_start) got = 1;
      if (which == 1 && read_start) got = 1;
      if (which == 2 && rd_update) got = 1;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic t_reset();
    check(busy == 0 && mdio_oe == 0 && rd_update == 0, "R1", "busy/oe/upd", {busy, mdio_oe, rd_update}, 0);
    check(write_start == 0 && read_start == 0, "R1", "start pulses", {write_start, read_start}, 0);
    check(rd_data == 0 && link_fail == 0 && scan_invalid == 0, "R1", "data/flags",
          {rd_data, link_fail, scan_invalid}, 0);
  endtask

  task automatic t_write(input logic np);
    bit got; int w0;
    no_pre = np; phy_addr = 5'h0A; reg_addr = 5'h11; wr_data = np ? 16'h3C5A : 16'hA5C3;
    w0 = n_wr;
    @(negedge clk) req_write = 1;
    wait_pulse(0, got);
    req_write = 0;
    check(got, "R4", "write_start seen", got, 1);
    check(busy, "R8", "busy at start", busy, 1);
    @(negedge clk);
    check(!write_start, "R4", "write_start one cycle", write_start, 0);
    wait_idle();
    @(negedge clk);
    check(n_wr == w0 + 1, "R3", "write frames", n_wr, w0 + 1);
    check(lw_phy == 5'h0A && lw_reg == 5'h11, "R3", "addresses", {lw_phy, lw_reg}, {5'h0A, 5'h11});
    check(lw_data == wr_data, "R3", "write data", lw_data, wr_data);
    check(lw_ta == 2'b10, "R3", "write turnaround", lw_ta, 2);
    check(last_pre == (np ? 0 : 32), "R3", "preamble length", last_pre, np ? 0 : 32);
    check(lw_busy, "R8", "busy during last bit", lw_busy, 1);
    no_pre = 0;
  endtask

  task automatic t_read();
    bit got; int r0;
    phy_regs[3] = 16'h1234; reg_addr = 5'd3; r0 = n_rd; rd_oe_err = 0;
    @(negedge clk) req_read = 1;
    wait_pulse(1, got);
    req_read = 0;
    check(got, "R4", "read_start seen", got, 1);
    wait_pulse(2, got);
    check(got && rd_data == 16'h1234, "R5", "read data", rd_data, 16'h1234);
    @(negedge clk);
    check(!rd_update, "R5", "update one cycle", rd_update, 0);
    check(n_rd == r0 + 1 && last_op == 2'b10, "R3", "read opcode", last_op, 2);
    check(rd_oe_err == 0, "R5", "released during TA/data", rd_oe_err, 0);
    wait_idle();
  endtask

  task automatic t_div(input logic [7:0] d);
    int per, hi;
    div = d;
    for (int i = 0; i < 3; i++) begin
      @(posedge mdc);
    end
    @(negedge clk);
    while (!(mdc && !p_mdc)) @(negedge clk);
    per = 0; hi = 0;
    do begin
      @(negedge clk); per++;
      if (mdc) hi++;
    end while (!(mdc && !p_mdc));
    check(per == ((d < 2) ? 2 : d), "R2", "mdc period", per, (d < 2) ? 2 : d);
    check(hi >= 1 && hi < per, "R2", "mdc high time", hi, per / 2);
    div = 8'd4;
  endtask

  task automatic t_priority();
    bit got;
    reg_addr = 5'd3;
    @(negedge clk) begin req_write = 1; req_read = 1; req_scan = 1; end
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (write_start || read_start) break;
    end
    check(write_start && !read_start, "R4", "write first", {write_start, read_start}, 2);
    req_write = 0;
    wait_pulse(1, got);
    check(got, "R4", "read second", got, 1);
    req_read = 0; req_scan = 0;
    wait_idle();
  endtask

  task automatic t_scan();
    bit got; int idle_gap = 0, rs = 0, r0;
    phy_regs[1] = 16'h0000; reg_addr = 5'd1;
    @(negedge clk) req_scan = 1;
    while (!busy) @(negedge clk);
    check(scan_invalid, "R7", "invalid at scan start", scan_invalid, 1);
    wait_pulse(2, got);
    check(got && !scan_invalid, "R7", "invalid cleared", scan_invalid, 0);
    check(link_fail, "R7", "link fail bit2=0", link_fail, 1);
    phy_regs[1] = 16'h0004;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) idle_gap++;
      if (read_start) rs++;
      if (rd_update) break;
    end
    check(rd_data == 16'h0004 && !link_fail, "R7", "link ok bit2=1", {rd_data, link_fail}, 16'h0004 << 1);
    check(idle_gap == 0, "R8", "back-to-back frames", idle_gap, 0);
    check(rs == 0, "R7", "no read_start in scan", rs, 0);
    req_scan = 0;
    wait_idle();
    r0 = n_rd;
    repeat (600) @(negedge clk);
    check(!busy && n_rd == r0, "R7", "scan stops", n_rd, r0);
    check(!scan_invalid, "R7", "invalid stays low", scan_invalid, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write(0);
    t_write(1);
    t_read();
    t_div(8'd0);
    t_div(8'd1);
    t_div(8'd6);
    t_div(8'd7);
    t_priority();
    t_scan();
    check(edge_err == 0, "R6", "data change off MDC fall", edge_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule